// File: doc/BRIEF.md
# Parallel Flash Programming Mode Controller

This block controls a small on-chip program store while the chip sits in its parallel programming mode. Three static mode-select inputs decide whether programming mode is active at all. Inside that mode, a chip-enable strobe, an output-enable strobe, a high-voltage-present indication and four auxiliary control lines together select one of three operations: read, program or program-verify. The operation acts on a 16-bit address and an 8-bit data bus. The data bus is modelled as separate in and out vectors plus an output enable.

A program operation writes the addressed byte on the rising edge of chip enable, and only if the low pulse lasted between `PULSE_MIN` and `PULSE_MAX` clock cycles. A pulse outside that window, or one broken off early, writes nothing and raises an error flag. One reserved address selects an 8-bit option register rather than the array. Programming that register can only clear bits. One option bit locks array readout. A second option bit denies table reads that come from external code space.

The controller is one state machine. Its states are `S_NORMAL`, `S_IDLE`, `S_READ`, `S_PULSE` and `S_VERIFY`. Any state goes to `S_NORMAL` as soon as the mode selects are wrong. `S_NORMAL` goes to `S_IDLE` once they are right. `S_IDLE` goes to `S_READ`, `S_PULSE` or `S_VERIFY` on the matching decoded operation. `S_READ` and `S_VERIFY` return to `S_IDLE` when their operation ends. `S_PULSE` returns to `S_IDLE` in two cases: when chip enable rises, which writes the byte or flags an error, and when the program conditions drop while chip enable is still low, which flags an error.

Top module: `flashprog_ctrl`

## Requirements
- R1: Programming mode holds only while `mode_sel_a`=1, `mode_sel_b`=0 and `mode_sel_c`=1. In any other case, after the next edge the state is normal, `data_oe`=0 and `prog_err`=0, whatever the strobes do.
- R2: Read is selected by `hv_ok`=0, `ce_n`=0, `oe_n`=0 and `aux_ctl`=0. One edge after it is selected, `data_oe`=1 and `data_out` holds the array byte at `addr[11:0]`; the upper address bits alias. A new `addr` shows after one edge.
- R3: Program is selected by `hv_ok`=1, `ce_n`=0, `oe_n`=1 and `aux_ctl`=0. `data_in` is stored at `addr` on the edge that first sees `ce_n` high again. `data_oe` stays 0 for the whole pulse.
- R4: Let N be the number of edges that sample `ce_n` low. If N is below `PULSE_MIN` or above `PULSE_MAX`, nothing is written and `prog_err`=1 after the closing edge. The same holds if `hv_ok`, `oe_n` or `aux_ctl` leave the program combination while `ce_n` is low. N equal to either limit is accepted, and an accepted pulse clears `prog_err`.
- R5: Verify is selected by `hv_ok`=1, `ce_n`=1, `oe_n`=0 and `aux_ctl`=0. One edge later the stored byte at `addr` is driven.
- R6: Address `OPT_ADDR` (default 16'hFFFF) selects the option register. It is 8'hFF after reset, reads return it, and programming it stores old AND `data_in`. Bit 0 is the lock bit (0 = locked) and bit 1 is table freedom (0 = restricted).
- R7: While option bit 0 is 0, every read or verify of an array address drives `FILL_BYTE` (8'h00). The option register itself stays readable.
- R8: The first edge that samples `oe_n`=1 ends read or verify: `data_oe`=0 after it. `data_out` is 0 whenever `data_oe`=0.
- R9: One edge after `tbl_addr` is sampled, `tbl_rdata` gives the array byte for that address and `tbl_denied`=0, provided `tbl_addr` < `DEPTH` and either `tbl_from_ext`=0 or option bit 1 is 1. For `tbl_addr` >= `DEPTH`, both outputs are 0. The lock bit has no effect on this path.
- R10: When `tbl_from_ext`=1, option bit 1 is 0 and `tbl_addr` < `DEPTH`, then one edge later `tbl_denied`=1 and `tbl_rdata`=0.
- R11: A non-zero `aux_ctl` decodes to no operation, so an active read stops driving the bus after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel_a | input | 1 | Mode select, must be 1 |
| mode_sel_b | input | 1 | Mode select, must be 0 |
| mode_sel_c | input | 1 | Mode select, must be 1 |
| hv_ok | input | 1 | Programming voltage present |
| ce_n | input | 1 | Chip enable, program pulse, active low |
| oe_n | input | 1 | Output enable, active low |
| aux_ctl | input | 4 | Auxiliary control lines, all 0 for any operation |
| addr | input | 16 | Operation address |
| data_in | input | 8 | Data bus, inbound |
| data_out | output | 8 | Data bus, outbound |
| data_oe | output | 1 | Data bus drive enable |
| prog_err | output | 1 | Last program pulse rejected |
| tbl_addr | input | 16 | Table-read address |
| tbl_from_ext | input | 1 | Table read issued from external code |
| tbl_rdata | output | 8 | Table-read data |
| tbl_denied | output | 1 | Table read refused |

## Verification
A state register stuck in or wrongly left `S_READ` or `S_VERIFY` shows up as `data_oe` out of step with `oe_n` one edge later. A wrong write decision in `S_PULSE` shows up two ways: as `prog_err` right after the closing edge, and as a wrong byte on the next verify. The pulse is driven at both window limits and one cycle outside each, so an off-by-one in the width counter changes the visible outcome. Damage to the option register is visible on the next read of the reserved address, as array data leaking or disappearing while locked, and one edge later on the table-read outputs.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

    typedef enum logic [2:0] {
        S_NORMAL,
        S_IDLE,
        S_READ,
        S_PULSE,
        S_VERIFY
    } fp_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_PROG,
        OP_VERIFY
    } fp_op_e;

    localparam int OPT_LOCK_BIT = 0;
    localparam int OPT_TBL_BIT  = 1;

endpackage

// File: rtl/fp_op_decode.sv
module fp_op_decode
    import flashprog_pkg::*;
#(
    parameter int AUX_W = 4
) (
    input  logic             mode_sel_a,
    input  logic             mode_sel_b,
    input  logic             mode_sel_c,
    input  logic             hv_ok,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic [AUX_W-1:0] aux_ctl,
    output logic             mode_ok,
    output fp_op_e           op
);

    assign mode_ok = mode_sel_a && !mode_sel_b && mode_sel_c;

    always_comb begin
        op = OP_NONE;
        if (aux_ctl == '0) begin
            unique case ({hv_ok, ce_n, oe_n})
                3'b000:  op = OP_READ;
                3'b101:  op = OP_PROG;
                3'b110:  op = OP_VERIFY;
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fp_pulse_timer.sv
module fp_pulse_timer #(
    parameter int PULSE_MIN = 23750,
    parameter int PULSE_MAX = 26250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic inc,
    output logic width_ok
);

    localparam int            CW  = $clog2(PULSE_MAX + 2);
    localparam logic [CW-1:0] SAT = CW'(PULSE_MAX + 1);
    localparam logic [CW-1:0] LO  = CW'(PULSE_MIN);
    localparam logic [CW-1:0] HI  = CW'(PULSE_MAX);

    logic [CW-1:0] cnt_q;

    // Counts edges that saw the strobe low; stops one past the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (inc && cnt_q != SAT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign width_ok = (cnt_q >= LO) && (cnt_q <= HI);

endmodule

// File: rtl/fp_store.sv
module fp_store
    import flashprog_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 4096,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = '1,
    parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              tbl_from_ext,
    output logic [DATA_W-1:0] tbl_rdata,
    output logic              tbl_denied,
    output logic              lock_n,
    output logic              tbl_free
);

    localparam int IW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] opt_q;
    logic              wr_opt;
    logic              tbl_int;

    assign wr_opt   = wr_en && (wr_addr == OPT_ADDR);
    assign lock_n   = opt_q[OPT_LOCK_BIT];
    assign tbl_free = opt_q[OPT_TBL_BIT];
    assign tbl_int  = tbl_addr < ADDR_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (wr_en && !wr_opt) begin
            mem[wr_addr[IW-1:0]] <= wr_data;
        end
    end

    // Option cells only lose ones, as a programmed cell would.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= '1;
        end else if (wr_opt) begin
            opt_q <= opt_q & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_addr == OPT_ADDR) begin
            rd_q <= opt_q;
        end else if (!lock_n) begin
            rd_q <= FILL_BYTE;
        end else begin
            rd_q <= mem[rd_addr[IW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_rdata  <= '0;
            tbl_denied <= 1'b0;
        end else if (!tbl_int) begin
            tbl_rdata  <= '0;
            tbl_denied <= 1'b0;
        end else if (tbl_from_ext && !tbl_free) begin
            tbl_rdata  <= '0;
            tbl_denied <= 1'b1;
        end else begin
            tbl_rdata  <= mem[tbl_addr[IW-1:0]];
            tbl_denied <= 1'b0;
        end
    end

endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
    import flashprog_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 4096,
    parameter int                AUX_W     = 4,
    parameter int                PULSE_MIN = 23750,
    parameter int                PULSE_MAX = 26250,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = '1,
    parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel_a,
    input  logic              mode_sel_b,
    input  logic              mode_sel_c,
    input  logic              hv_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [AUX_W-1:0]  aux_ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              prog_err,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              tbl_from_ext,
    output logic [DATA_W-1:0] tbl_rdata,
    output logic              tbl_denied
);

    fp_state_e         st_q, st_d;
    fp_op_e            op;
    logic              mode_ok;
    logic              pulse_start, pulse_inc, width_ok;
    logic              wr_en, err_set;
    logic [DATA_W-1:0] rd_q;
    logic              lock_n, tbl_free;

    fp_op_decode #(.AUX_W(AUX_W)) u_dec (
        .mode_sel_a (mode_sel_a),
        .mode_sel_b (mode_sel_b),
        .mode_sel_c (mode_sel_c),
        .hv_ok      (hv_ok),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .aux_ctl    (aux_ctl),
        .mode_ok    (mode_ok),
        .op         (op)
    );

    fp_pulse_timer #(.PULSE_MIN(PULSE_MIN), .PULSE_MAX(PULSE_MAX)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pulse_start),
        .inc      (pulse_inc),
        .width_ok (width_ok)
    );

    fp_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .OPT_ADDR  (OPT_ADDR),
        .FILL_BYTE (FILL_BYTE)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (addr),
        .wr_data      (data_in),
        .rd_addr      (addr),
        .rd_q         (rd_q),
        .tbl_addr     (tbl_addr),
        .tbl_from_ext (tbl_from_ext),
        .tbl_rdata    (tbl_rdata),
        .tbl_denied   (tbl_denied),
        .lock_n       (lock_n),
        .tbl_free     (tbl_free)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and strobes
    always_comb begin
        st_d        = st_q;
        pulse_start = 1'b0;
        pulse_inc   = 1'b0;
        wr_en       = 1'b0;
        err_set     = 1'b0;
        if (!mode_ok) begin
            st_d = S_NORMAL;
        end else begin
            unique case (st_q)
                S_NORMAL: st_d = S_IDLE;
                S_IDLE: begin
                    unique case (op)
                        OP_READ:   st_d = S_READ;
                        OP_VERIFY: st_d = S_VERIFY;
                        OP_PROG: begin
                            st_d        = S_PULSE;
                            pulse_start = 1'b1;
                        end
                        default:   st_d = S_IDLE;
                    endcase
                end
                S_READ: begin
                    if (op != OP_READ) st_d = S_IDLE;
                end
                S_VERIFY: begin
                    if (op != OP_VERIFY) st_d = S_IDLE;
                end
                S_PULSE: begin
                    if (ce_n) begin
                        st_d = S_IDLE;
                        if (width_ok) wr_en   = 1'b1;
                        else          err_set = 1'b1;
                    end else if (op != OP_PROG) begin
                        st_d    = S_IDLE;
                        err_set = 1'b1;
                    end else begin
                        pulse_inc = 1'b1;
                    end
                end
                default: st_d = S_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_err <= 1'b0;
        end else if (st_d == S_NORMAL) begin
            prog_err <= 1'b0;
        end else if (err_set) begin
            prog_err <= 1'b1;
        end else if (wr_en) begin
            prog_err <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            S_READ, S_VERIFY: data_oe = 1'b1;
            default:          data_oe = 1'b0;
        endcase
        data_out = data_oe ? rd_q : '0;
    end

endmodule

// File: rtl/fp_ctrl_chk.sv
module fp_ctrl_chk
    import flashprog_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 4096,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = '1,
    parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sel_a,
    input logic              mode_sel_b,
    input logic              mode_sel_c,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              prog_err,
    input fp_state_e         st_q,
    input logic              lock_n,
    input logic              tbl_free,
    input logic [ADDR_W-1:0] tbl_addr,
    input logic              tbl_from_ext,
    input logic [DATA_W-1:0] tbl_rdata,
    input logic              tbl_denied
);

    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_sel_a && !mode_sel_b && mode_sel_c) |=> (!data_oe && !prog_err)); // R1

    AST_ERR_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_NORMAL) |-> !prog_err); // R1

    AST_QUIET_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !data_oe); // R3

    AST_LOCK_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(addr) != OPT_ADDR && !$past(lock_n)) |-> data_out == FILL_BYTE); // R7

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (!data_oe && data_out == '0)); // R8

    AST_TBL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_from_ext && !tbl_free && tbl_addr < ADDR_W'(DEPTH)) |=> (tbl_denied && tbl_rdata == '0)); // R10

endmodule

bind flashprog_ctrl fp_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .OPT_ADDR  (OPT_ADDR),
    .FILL_BYTE (FILL_BYTE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel_a   (mode_sel_a),
    .mode_sel_b   (mode_sel_b),
    .mode_sel_c   (mode_sel_c),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .addr         (addr),
    .data_out     (data_out),
    .data_oe      (data_oe),
    .prog_err     (prog_err),
    .st_q         (st_q),
    .lock_n       (lock_n),
    .tbl_free     (tbl_free),
    .tbl_addr     (tbl_addr),
    .tbl_from_ext (tbl_from_ext),
    .tbl_rdata    (tbl_rdata),
    .tbl_denied   (tbl_denied)
);

// File: tb/sim_flashprog_ctrl.sv
`timescale 1ns/1ps
module sim_flashprog_ctrl;

    localparam int P_MIN = 20;
    localparam int P_MAX = 24;
    localparam int WD_CYCLES = 20000;

    localparam int SEL_DATA = 0;
    localparam int SEL_OE   = 1;
    localparam int SEL_ERR  = 2;
    localparam int SEL_TRD  = 3;
    localparam int SEL_TDN  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel_a = 1'b0, mode_sel_b = 1'b1, mode_sel_c = 1'b0;
    logic        hv_ok = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  aux_ctl = '0;
    logic [15:0] addr = '0, tbl_addr = '0;
    logic [7:0]  data_in = '0;
    logic        tbl_from_ext = 1'b0;
    logic [7:0]  data_out, tbl_rdata;
    logic        data_oe, prog_err, tbl_denied;

    always #2 clk = ~clk;

    flashprog_ctrl #(.PULSE_MIN(P_MIN), .PULSE_MAX(P_MAX)) u0 (
        .clk, .rst_n, .mode_sel_a, .mode_sel_b, .mode_sel_c, .hv_ok,
        .ce_n, .oe_n, .aux_ctl, .addr, .data_in, .data_out, .data_oe,
        .prog_err, .tbl_addr, .tbl_from_ext, .tbl_rdata, .tbl_denied
    );

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    item_t it;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic [7:0] act;

    // Monitor: compares every queued expectation at the next falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                SEL_DATA: act = data_out;
                SEL_OE:   act = {7'd0, data_oe};
                SEL_ERR:  act = {7'd0, prog_err};
                SEL_TRD:  act = tbl_rdata;
                default:  act = {7'd0, tbl_denied};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h at %0t",
                         it.req, it.sel, act, it.exp, $time);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(string r, int sel, logic [7:0] v);
        item_t x;
        x.req = r; x.sel = sel; x.exp = v;
        sb_q.push_back(x);
    endtask

    task automatic prog_byte(logic [15:0] a, logic [7:0] d, int n, string r, logic e);
        addr = a; data_in = d; hv_ok = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
        tick(1);
        ce_n = 1'b0;
        tick(n);
        push("R3", SEL_OE, 8'h00);
        ce_n = 1'b1;
        tick(1);
        push(r, SEL_ERR, {7'd0, e});
    endtask

    task automatic verify_byte(logic [15:0] a, logic [7:0] d, string r);
        addr = a; hv_ok = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
        tick(1);
        push(r, SEL_OE, 8'h01);
        push(r, SEL_DATA, d);
        oe_n = 1'b1;
        tick(1);
        push("R8", SEL_OE, 8'h00);
        push("R8", SEL_DATA, 8'h00);
    endtask

    task automatic read_byte(logic [15:0] a, logic [7:0] d, string r);
        addr = a; hv_ok = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        tick(1);
        push(r, SEL_OE, 8'h01);
        push(r, SEL_DATA, d);
    endtask

    task automatic end_read();
        oe_n = 1'b1; ce_n = 1'b1;
        tick(1);
        push("R8", SEL_OE, 8'h00);
    endtask

    task automatic tbl_read(logic [15:0] a, logic ext, logic [7:0] d, logic den, string r);
        tbl_addr = a; tbl_from_ext = ext;
        tick(1);
        push(r, SEL_TRD, d);
        push(r, SEL_TDN, {7'd0, den});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        push("R1", SEL_OE, 8'h00);
        push("R1", SEL_ERR, 8'h00);
        rst_n = 1'b1;
        tick(1);
        // R1: strobes outside programming mode drive nothing
        ce_n = 1'b0; oe_n = 1'b0;
        tick(2);
        push("R1", SEL_OE, 8'h00);
        ce_n = 1'b1; oe_n = 1'b1;
        mode_sel_a = 1'b1; mode_sel_b = 1'b0; mode_sel_c = 1'b1;
        tick(2);

        // R3/R5: program then verify
        prog_byte(16'h0012, 8'hA5, 22, "R3", 1'b0);
        verify_byte(16'h0012, 8'hA5, "R5");
        // R4: window limits accepted
        prog_byte(16'h0FFF, 8'h3C, P_MIN, "R4", 1'b0);
        verify_byte(16'h0FFF, 8'h3C, "R4");
        prog_byte(16'h0001, 8'h77, P_MAX, "R4", 1'b0);
        verify_byte(16'h0001, 8'h77, "R4");
        // R4: one short, one long
        prog_byte(16'h0012, 8'h00, P_MIN - 1, "R4", 1'b1);
        verify_byte(16'h0012, 8'hA5, "R4");
        push("R4", SEL_ERR, 8'h01);
        prog_byte(16'h0001, 8'h5A, P_MAX + 1, "R4", 1'b1);
        verify_byte(16'h0001, 8'h77, "R4");
        prog_byte(16'h0002, 8'hC3, 21, "R4", 1'b0);
        verify_byte(16'h0002, 8'hC3, "R5");
        // R4: pulse broken by loss of programming voltage
        addr = 16'h0001; data_in = 8'h11; hv_ok = 1'b1;
        tick(1);
        ce_n = 1'b0;
        tick(10);
        hv_ok = 1'b0;
        tick(1);
        push("R4", SEL_ERR, 8'h01);
        ce_n = 1'b1;
        tick(1);
        prog_byte(16'h0001, 8'h22, 40, "R4", 1'b1);
        verify_byte(16'h0001, 8'h77, "R4");

        // R2: reads, address change and aliasing
        read_byte(16'h0012, 8'hA5, "R2");
        addr = 16'h0FFF;
        tick(1);
        push("R2", SEL_DATA, 8'h3C);
        addr = 16'h1012;
        tick(1);
        push("R2", SEL_DATA, 8'hA5);
        // R11: non-zero auxiliary lines
        aux_ctl = 4'b0100;
        tick(1);
        push("R11", SEL_OE, 8'h00);
        push("R11", SEL_DATA, 8'h00);
        aux_ctl = 4'b0000;
        tick(1);
        push("R11", SEL_OE, 8'h01);
        // R1: leaving the mode mid-read clears bus and error
        mode_sel_b = 1'b1;
        tick(1);
        push("R1", SEL_OE, 8'h00);
        push("R1", SEL_ERR, 8'h00);
        mode_sel_b = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        tick(2);

        // R9: table reads, unrestricted
        tbl_read(16'h0012, 1'b1, 8'hA5, 1'b0, "R9");
        tbl_read(16'h2000, 1'b1, 8'h00, 1'b0, "R9");

        // R6: option register
        read_byte(16'hFFFF, 8'hFF, "R6");
        end_read();
        prog_byte(16'hFFFF, 8'hFD, 22, "R6", 1'b0);
        read_byte(16'hFFFF, 8'hFD, "R6");
        read_byte(16'h0012, 8'hA5, "R7");
        end_read();
        // R10 / R9 with restriction active
        tbl_read(16'h0012, 1'b1, 8'h00, 1'b1, "R10");
        tbl_read(16'h0012, 1'b0, 8'hA5, 1'b0, "R9");
        // R6 AND behaviour, which also sets the lock
        prog_byte(16'hFFFF, 8'hFE, 22, "R6", 1'b0);
        read_byte(16'hFFFF, 8'hFC, "R6");
        // R7: locked readout
        read_byte(16'h0012, 8'h00, "R7");
        end_read();
        verify_byte(16'h0002, 8'h00, "R7");
        read_byte(16'hFFFF, 8'hFC, "R7");
        end_read();
        tbl_read(16'h0002, 1'b0, 8'hC3, 1'b0, "R9");

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule